// File: doc/BRIEF.md
# Per-Line Pin Ownership and Drive Control

This block keeps the configuration of every line of a parallel I/O port and turns it into pad control signals. Each line can belong to the port controller itself or be handed to an on-chip peripheral. For a handed-over line, one of two peripherals (A or B) is routed to the pin. Each line also has an output-driver enable, an open-drain mode, a pull-up enable and a controller-owned output data bit. The pads receive a data value, a driver enable and a pull-up enable.

Each of the six settings has three addresses. Writing ones to the set address turns the marked lines on. Writing ones to the clear address turns them off. The status address reads the current word back. A bus address is split into a setting index in bits [4:2] and a slot in bits [1:0]. In open-drain mode a line never drives high: a selected 1 releases the pin, and only a selected 0 enables the driver.

Top module: `line_drive_ctrl`

## Requirements
- R1: After reset, every line is controller owned (ownership word all ones) and peripheral A is selected (route word all zeros). Output drivers are disabled, open-drain is off, pull-ups are on (pull word all ones) and the controller data word is zero.
- R2: The setting index in busAddr[4:2] is 0 ownership (1 = controller), 1 route (1 = peripheral B), 2 output enable, 3 open-drain, 4 pull-up, 5 controller data. When busWrEn is high and busAddr[1:0] is 0, the selected setting becomes set on every line whose busWdata bit is 1.
- R3: A write with busAddr[1:0] equal to 1 clears the selected setting on every line whose busWdata bit is 1. On both set and clear writes, lines whose data bit is 0 keep their value.
- R4: With busAddr[1:0] equal to 2, busRdata shows the selected setting word, combinationally from the address. Slot 3 and setting indices 6 and 7 read as zero.
- R5: On a controller-owned line, the source enable and data are that line's output-enable and controller-data settings.
- R6: On a peripheral-owned line, the source enable and data come from peripheral A when the route bit is 0 and from peripheral B when it is 1.
- R7: Without open-drain, padOe and padDo equal the source enable and data. With open-drain, padDo is 0 and padOe is high only when the source enable is 1 and the source data is 0.
- R8: padPullEn equals the pull-up setting of each line.
- R9: While busWrEn is low, no setting changes, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrEn | input | 1 | Write strobe |
| busAddr | input | 5 | Setting index [4:2], slot [1:0] |
| busWdata | input | NUM_LINES | Write mask |
| busRdata | output | NUM_LINES | Status readback |
| periphAOe | input | NUM_LINES | Peripheral A driver enable |
| periphADo | input | NUM_LINES | Peripheral A data |
| periphBOe | input | NUM_LINES | Peripheral B driver enable |
| periphBDo | input | NUM_LINES | Peripheral B data |
| padOe | output | NUM_LINES | Pad driver enable |
| padDo | output | NUM_LINES | Pad output data |
| padPullEn | output | NUM_LINES | Pad pull-up enable |

## Verification
The bench builds the block with NUM_LINES set to 4. At that width, every combination of a line's five settings and its four peripheral inputs (512 per line) can be swept, with the combination index offset differently on each line. Each step programs every setting through a set write followed by a clear write of the complement. It then reads all settings back and checks the pad outputs against values computed from the ownership, route and open-drain rules. Writes with the strobe low and reads of the unused address slots are covered as well.

// File: rtl/line_drive_pkg.sv
package line_drive_pkg;
  localparam int FIELD_CNT = 6;
  localparam int ADDR_W = 5;
  localparam int IDX_W = ADDR_W - 2;

  typedef enum logic [IDX_W-1:0] {
    F_OWN  = 3'd0,
    F_BSEL = 3'd1,
    F_OE   = 3'd2,
    F_MDRV = 3'd3,
    F_PULL = 3'd4,
    F_DOUT = 3'd5
  } field_e;

  typedef enum logic [1:0] {
    SLOT_SET  = 2'd0,
    SLOT_CLR  = 2'd1,
    SLOT_STAT = 2'd2
  } slot_e;

  typedef struct packed {
    logic [FIELD_CNT-1:0] setStb;
    logic [FIELD_CNT-1:0] clrStb;
    logic                 rdValid;
    logic [IDX_W-1:0]     rdField;
  } strobe_t;

  // per-setting reset level: ownership and pull-up come up as ones
  localparam logic [FIELD_CNT-1:0] RESET_ONES = 6'b010001;
endpackage

// File: rtl/line_drive_decode.sv
module line_drive_decode
  import line_drive_pkg::*;
(
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           stb
);
  logic [IDX_W-1:0] fieldIdx;
  logic [1:0]       slot;

  assign fieldIdx = busAddr[ADDR_W-1:2];
  assign slot     = busAddr[1:0];

  always_comb begin
    stb = '0;
    stb.rdField = fieldIdx;
    for (int f = 0; f < FIELD_CNT; f++) begin
      if (fieldIdx == IDX_W'(f)) begin
        stb.setStb[f] = busWrEn && (slot == SLOT_SET);
        stb.clrStb[f] = busWrEn && (slot == SLOT_CLR);
        stb.rdValid   = (slot == SLOT_STAT);
      end
    end
  end

  // R2 / R3: at most one setting touched per write, never both set and clear
  always_comb begin
    a_r2_single_strobe: assert ($onehot0({stb.setStb, stb.clrStb}));
  end
endmodule

// File: rtl/line_drive_datapath.sv
module line_drive_datapath
  import line_drive_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [NUM_LINES-1:0] busWdata,
  output logic [NUM_LINES-1:0] busRdata,
  input  logic [NUM_LINES-1:0] periphAOe,
  input  logic [NUM_LINES-1:0] periphADo,
  input  logic [NUM_LINES-1:0] periphBOe,
  input  logic [NUM_LINES-1:0] periphBDo,
  output logic [NUM_LINES-1:0] padOe,
  output logic [NUM_LINES-1:0] padDo,
  output logic [NUM_LINES-1:0] padPullEn
);
  logic [NUM_LINES-1:0] cfgQ [FIELD_CNT];
  logic [NUM_LINES-1:0] srcOe;
  logic [NUM_LINES-1:0] srcDo;

  for (genvar f = 0; f < FIELD_CNT; f++) begin : g_field
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfgQ[f] <= {NUM_LINES{RESET_ONES[f]}};
      end else if (stb.setStb[f]) begin
        cfgQ[f] <= cfgQ[f] | busWdata;
      end else if (stb.clrStb[f]) begin
        cfgQ[f] <= cfgQ[f] & ~busWdata;
      end
    end

    a_r2_set_marks: assert property (@(posedge clk) disable iff (!rstN)
      stb.setStb[f] |=> ((cfgQ[f] & $past(busWdata)) == $past(busWdata)));
    a_r3_clear_marks: assert property (@(posedge clk) disable iff (!rstN)
      stb.clrStb[f] |=> ((cfgQ[f] & $past(busWdata)) == '0));
    a_r3_unmarked_kept: assert property (@(posedge clk) disable iff (!rstN)
      (stb.setStb[f] || stb.clrStb[f]) |=>
        ((cfgQ[f] & ~$past(busWdata)) == ($past(cfgQ[f]) & ~$past(busWdata))));
    a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
      !(stb.setStb[f] || stb.clrStb[f]) |=> $stable(cfgQ[f]));
  end

  always_comb begin
    busRdata = '0;
    if (stb.rdValid) begin
      for (int f = 0; f < FIELD_CNT; f++) begin
        if (stb.rdField == IDX_W'(f)) busRdata = cfgQ[f];
      end
    end
  end

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    always_comb begin
      if (cfgQ[F_OWN][l]) begin
        srcOe[l] = cfgQ[F_OE][l];
        srcDo[l] = cfgQ[F_DOUT][l];
      end else if (cfgQ[F_BSEL][l]) begin
        srcOe[l] = periphBOe[l];
        srcDo[l] = periphBDo[l];
      end else begin
        srcOe[l] = periphAOe[l];
        srcDo[l] = periphADo[l];
      end
      if (cfgQ[F_MDRV][l]) begin
        padOe[l] = srcOe[l] & ~srcDo[l];
        padDo[l] = 1'b0;
      end else begin
        padOe[l] = srcOe[l];
        padDo[l] = srcDo[l];
      end
    end
  end

  assign padPullEn = cfgQ[F_PULL];

  // R7: an open-drain line never drives a high level
  a_r7_no_high_drive: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ[F_MDRV] & padOe & padDo) == '0);
  // R5: controller-owned lines never enable the driver when the output-enable setting is off
  a_r5_owned_oe: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ[F_OWN] & ~cfgQ[F_OE] & padOe) == '0);
endmodule

// File: rtl/line_drive_ctrl.sv
module line_drive_ctrl
  import line_drive_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWrEn,
  input  logic [4:0]           busAddr,
  input  logic [NUM_LINES-1:0] busWdata,
  output logic [NUM_LINES-1:0] busRdata,
  input  logic [NUM_LINES-1:0] periphAOe,
  input  logic [NUM_LINES-1:0] periphADo,
  input  logic [NUM_LINES-1:0] periphBOe,
  input  logic [NUM_LINES-1:0] periphBDo,
  output logic [NUM_LINES-1:0] padOe,
  output logic [NUM_LINES-1:0] padDo,
  output logic [NUM_LINES-1:0] padPullEn
);
  strobe_t stb;

  line_drive_decode u_decode (
    .busWrEn (busWrEn),
    .busAddr (busAddr),
    .stb     (stb)
  );

  line_drive_datapath #(.NUM_LINES(NUM_LINES)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .periphAOe (periphAOe),
    .periphADo (periphADo),
    .periphBOe (periphBOe),
    .periphBDo (periphBDo),
    .padOe     (padOe),
    .padDo     (padDo),
    .padPullEn (padPullEn)
  );
endmodule

// File: tb/line_drive_ctrl_bench.sv
module line_drive_ctrl_bench;
  localparam int N = 4;
  localparam int COMBOS = 512;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         busWrEn = 1'b0;
  logic [4:0]   busAddr = '0;
  logic [N-1:0] busWdata = '0;
  logic [N-1:0] busRdata;
  logic [N-1:0] periphAOe = '0, periphADo = '0, periphBOe = '0, periphBDo = '0;
  logic [N-1:0] padOe, padDo, padPullEn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  line_drive_ctrl #(.NUM_LINES(N)) u_line_drive_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .periphAOe(periphAOe), .periphADo(periphADo),
    .periphBOe(periphBOe), .periphBDo(periphBDo),
    .padOe(padOe), .padDo(padDo), .padPullEn(padPullEn)
  );

  task automatic check(input string req, input string what, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic busWrite(input int field, input int slot, input logic [N-1:0] data);
    @(negedge clk);
    busWrEn = 1'b1;
    busAddr = 5'((field << 2) | slot);
    busWdata = data;
    @(negedge clk);
    busWrEn = 1'b0;
    busWdata = '0;
  endtask

  task automatic readStat(input int field, output logic [N-1:0] val);
    busAddr = 5'((field << 2) | 2);
    #1;
    val = busRdata;
  endtask

  // per-line combo bits: 0 own, 1 bsel, 2 oe, 3 mdrv, 4 dout, 5 aOe, 6 aDo, 7 bOe, 8 bDo
  function automatic logic [8:0] comboOf(input int c, input int l);
    return 9'((c + l * 37) % COMBOS);
  endfunction

  initial begin
    logic [N-1:0] rd;
    logic [N-1:0] want [6];
    logic [N-1:0] expOe, expDo;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int f = 0; f < 6; f++) begin
      readStat(f, rd);
      check("R1", $sformatf("reset field %0d", f), rd, (f == 0 || f == 4) ? '1 : '0);
    end
    check("R1", "reset padOe", padOe, '0);
    check("R8", "reset padPullEn", padPullEn, '1);

    // R9: writes with strobe low change nothing
    @(negedge clk);
    busWrEn = 1'b0; busAddr = 5'(2 << 2); busWdata = '1;
    @(negedge clk);
    busAddr = 5'((0 << 2) | 1);
    @(negedge clk);
    busWdata = '0;
    readStat(2, rd); check("R9", "oe after idle set", rd, '0);
    readStat(0, rd); check("R9", "own after idle clear", rd, '1);

    // R4: unused slot and indices read zero
    busAddr = 5'((4 << 2) | 3); #1; check("R4", "slot 3", busRdata, '0);
    busAddr = 5'((6 << 2) | 2); #1; check("R4", "index 6", busRdata, '0);
    busAddr = 5'((7 << 2) | 2); #1; check("R4", "index 7", busRdata, '0);

    // R3: zero mask bits keep their value (partial clear of pull)
    busWrite(4, 1, N'(4'b0101));
    readStat(4, rd); check("R3", "partial clear", rd, N'(4'b1010));
    busWrite(4, 0, N'(4'b0001));
    readStat(4, rd); check("R2", "partial set", rd, N'(4'b1011));

    for (int c = 0; c < COMBOS; c++) begin
      for (int f = 0; f < 6; f++) want[f] = '0;
      for (int l = 0; l < N; l++) begin
        logic [8:0] k;
        k = comboOf(c, l);
        want[0][l] = k[0]; want[1][l] = k[1]; want[2][l] = k[2];
        want[3][l] = k[3]; want[5][l] = k[4]; want[4][l] = k[0] ^ k[3];
        periphAOe[l] = k[5]; periphADo[l] = k[6];
        periphBOe[l] = k[7]; periphBDo[l] = k[8];
      end
      for (int f = 0; f < 6; f++) begin
        busWrite(f, 0, want[f]);
        busWrite(f, 1, ~want[f]);
      end
      for (int f = 0; f < 6; f++) begin
        readStat(f, rd);
        check("R2", $sformatf("combo %0d field %0d", c, f), rd, want[f]);
      end
      for (int l = 0; l < N; l++) begin
        logic so, sd;
        if (want[0][l]) begin so = want[2][l]; sd = want[5][l]; end
        else if (want[1][l]) begin so = periphBOe[l]; sd = periphBDo[l]; end
        else begin so = periphAOe[l]; sd = periphADo[l]; end
        expOe[l] = want[3][l] ? (so & ~sd) : so;
        expDo[l] = want[3][l] ? 1'b0 : sd;
      end
      check("R5 R6 R7", $sformatf("combo %0d padOe", c), padOe, expOe);
      check("R5 R6 R7", $sformatf("combo %0d padDo", c), padDo, expDo);
      check("R8", $sformatf("combo %0d pull", c), padPullEn, want[4]);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule